// File: doc/BRIEF.md
# Microcoded ALU with Post-Shifter and Status Flags

This block is the arithmetic heart of a microcoded data path. A six-bit control word, taken straight from the current microinstruction, picks one of four functions (AND, OR, complement of B, add). It can also zero either operand, complement operand A before the function, and inject a carry into the adder. Operand A arrives from a holding register and operand B from a shared bus. The ALU result then passes through a small shifter that a separate two-bit field controls. The shifted value is what goes back onto the result bus.

Two status bits are derived from the unshifted ALU result: a negative flag (the top bit) and a zero flag (every bit clear). They are stored in one-bit flip-flops when a flag-enable input is high. The sequencer can then branch on them in the following microinstruction. The word width and the left-shift distance are parameters.

Top module: `alu_shift_core`

## Requirements
- R1: `ctrl` carries the fields F0,F1,ENA,ENB,INVA,INC at bit positions 5,4,3,2,1,0. {F0,F1} selects the function: 00 = A AND B, 01 = A OR B, 10 = NOT B, 11 = A + B + carry.
- R2: When ENA (ctrl[3]) is 0, operand A is taken as zero. When ENB (ctrl[2]) is 0, operand B is taken as zero.
- R3: When INVA (ctrl[1]) is 1, the gated A operand is bitwise complemented before the function is applied. This holds for every function.
- R4: INC (ctrl[0]) is the adder's carry-in and adds one to the sum. It has no effect on the AND, OR and NOT B functions.
- R5: The following control words give the listed results, with no shift applied:
  - 011000 gives A.
  - 010100 gives B.
  - 111100 gives A+B.
  - 111101 gives A+B+1.
  - 111001 gives A+1.
  - 110101 gives B+1.
  - 111111 gives B-A.
  - 110110 gives B-1.
  - 111011 gives -A.
  - 001100 gives A AND B.
  - 011100 gives A OR B.
  - 010000 gives 0.
  - 110001 gives 1.
  - 110010 gives -1.
- R6: When `shift_ctrl[1]` is 1, `result` is the ALU output shifted left by SHL_DIST bits, with zeros filling the low bits.
- R7: When `shift_ctrl` is 01, `result` is the ALU output shifted right by one bit, with the top bit copied into the vacated position.
- R8: With `shift_ctrl` equal to 11, the left shift wins. With `shift_ctrl` equal to 00, `result` equals the ALU output.
- R9: On a rising clock edge with `flag_en` high, `neg_q` takes bit W-1 of the unshifted ALU output.
- R10: On a rising clock edge with `flag_en` high, `zero_q` takes 1 exactly when the unshifted ALU output is all zero. A value that only the shifter turns into zero does not set it.
- R11: Both flags reset to 0 asynchronously when `rst_n` is low. They hold their value on any edge where `flag_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags are captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| ctrl | input | 6 | ALU control word {F0,F1,ENA,ENB,INVA,INC} |
| shift_ctrl | input | 2 | Shifter control: bit 1 left shift, bit 0 arithmetic right shift |
| opnd_a | input | W | Operand A from the holding register |
| opnd_b | input | W | Operand B from the shared bus |
| flag_en | input | 1 | Enables capture of the status flags |
| result | output | W | Shifted ALU result |
| neg_q | output | 1 | Registered negative flag |
| zero_q | output | 1 | Registered zero flag |

## Verification
The main instance is built with W = 8 and SHL_DIST = 2. This makes it cheap to sweep all 64 control words against every A value and a spread of B values, with the shift mode rotating. Every carry pattern of the 8-bit adder is covered, and so is every sign case of the right shift.

A second instance keeps the default W = 32 and SHL_DIST = 8. It checks the named control-word encodings against full-width arithmetic. The flag stage is driven by a pseudo-random stream with `flag_en` toggling. Directed cases cover values that the shifter alone turns to zero or makes negative.

// File: rtl/alu_shift_pkg.sv
package alu_shift_pkg;

  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOTB = 2'b10,
    FN_ADD  = 2'b11
  } alu_fn_e;

  // Field order fixed by the microinstruction layout (MSB first).
  typedef struct packed {
    logic f0;
    logic f1;
    logic ena;
    logic enb;
    logic inva;
    logic inc;
  } alu_ctrl_t;

  typedef struct packed {
    logic sll;
    logic sra;
  } shf_ctrl_t;

  localparam int unsigned CTRL_W = $bits(alu_ctrl_t);
  localparam int unsigned SHFC_W = $bits(shf_ctrl_t);

endpackage

// File: rtl/alu_operand_gate.sv
module alu_operand_gate #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ena,
  input  logic         enb,
  input  logic         inva,
  output logic [W-1:0] a_eff,
  output logic [W-1:0] b_eff
);

  function automatic logic [W-1:0] gate_word(input logic [W-1:0] v, input logic en);
    return en ? v : '0;
  endfunction

  function automatic logic [W-1:0] cond_invert(input logic [W-1:0] v, input logic inv);
    return v ^ {W{inv}};
  endfunction

  always_comb begin
    a_eff = cond_invert(gate_word(a_in, ena), inva);
    b_eff = gate_word(b_in, enb);
  end

endmodule

// File: rtl/alu_func_unit.sv
module alu_func_unit
  import alu_shift_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  alu_fn_e      fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res
);

  function automatic logic [W-1:0] add_cin(input logic [W-1:0] x,
                                           input logic [W-1:0] y,
                                           input logic         c);
    return x + y + {{(W-1){1'b0}}, c};
  endfunction

  logic [W-1:0] sum_w;
  assign sum_w = add_cin(a, b, cin);

  always_comb begin
    unique case (fn)
      FN_AND:  res = a & b;
      FN_OR:   res = a | b;
      FN_NOTB: res = ~b;
      FN_ADD:  res = sum_w;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/alu_post_shifter.sv
module alu_post_shifter
  import alu_shift_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter int unsigned SHL_DIST = 8
) (
  input  shf_ctrl_t    sc,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] left_w;
  logic [W-1:0] right_w;

  generate
    if (SHL_DIST == 0) begin : g_no_left
      assign left_w = din;
    end else if (SHL_DIST >= W) begin : g_left_all
      assign left_w = '0;
    end else begin : g_left
      assign left_w = {din[W-1-SHL_DIST:0], {SHL_DIST{1'b0}}};
    end
  endgenerate

  assign right_w = {din[W-1], din[W-1:1]};

  always_comb begin
    if (sc.sll)      dout = left_w;
    else if (sc.sra) dout = right_w;
    else             dout = din;
  end

endmodule

// File: rtl/alu_flag_latch.sv
module alu_flag_latch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] alu_val,
  output logic         neg_q,
  output logic         zero_q
);

  logic neg_d;
  logic zero_d;
  assign neg_d  = alu_val[W-1];
  assign zero_d = (alu_val == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q  <= 1'b0;
      zero_q <= 1'b0;
    end else if (en) begin
      neg_q  <= neg_d;
      zero_q <= zero_d;
    end
  end

endmodule

// File: rtl/alu_shift_core.sv
module alu_shift_core
  import alu_shift_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter int unsigned SHL_DIST = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [5:0]   ctrl,
  input  logic [1:0]   shift_ctrl,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         flag_en,
  output logic [W-1:0] result,
  output logic         neg_q,
  output logic         zero_q
);

  alu_ctrl_t    cw;
  shf_ctrl_t    sw;
  alu_fn_e      fn_sel;
  logic [W-1:0] a_eff;
  logic [W-1:0] b_eff;
  logic [W-1:0] alu_res;

  assign cw     = alu_ctrl_t'(ctrl);
  assign sw     = shf_ctrl_t'(shift_ctrl);
  assign fn_sel = alu_fn_e'({cw.f0, cw.f1});

  alu_operand_gate #(.W(W)) u_gate (
    .a_in  (opnd_a),
    .b_in  (opnd_b),
    .ena   (cw.ena),
    .enb   (cw.enb),
    .inva  (cw.inva),
    .a_eff (a_eff),
    .b_eff (b_eff)
  );

  alu_func_unit #(.W(W)) u_func (
    .fn  (fn_sel),
    .a   (a_eff),
    .b   (b_eff),
    .cin (cw.inc),
    .res (alu_res)
  );

  alu_post_shifter #(.W(W), .SHL_DIST(SHL_DIST)) u_shift (
    .sc   (sw),
    .din  (alu_res),
    .dout (result)
  );

  alu_flag_latch #(.W(W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (flag_en),
    .alu_val (alu_res),
    .neg_q   (neg_q),
    .zero_q  (zero_q)
  );

endmodule

// File: rtl/alu_shift_core_chk.sv
module alu_shift_core_chk #(
  parameter int unsigned W        = 32,
  parameter int unsigned SHL_DIST = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   shift_ctrl,
  input logic         flag_en,
  input logic [W-1:0] alu_res,
  input logic [W-1:0] result,
  input logic         neg_q,
  input logic         zero_q
);

  // R11
  flags_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!neg_q && !zero_q));

  // R11
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_en |=> $stable({neg_q, zero_q}));

  // R9
  neg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_en |=> (neg_q == $past(alu_res[W-1])));

  // R10
  zero_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_en |=> (zero_q == ($past(alu_res) == '0)));

  // R8
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_ctrl == 2'b00) |-> (result == alu_res));

  // R7
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_ctrl == 2'b01) |-> (result[W-1] == alu_res[W-1] && result[W-2:0] == alu_res[W-1:1]));

  // R6
  left_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_ctrl[1] && SHL_DIST > 0 && SHL_DIST < W) |-> (result[0] == 1'b0));

endmodule

bind alu_shift_core alu_shift_core_chk #(.W(W), .SHL_DIST(SHL_DIST)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .shift_ctrl (shift_ctrl),
  .flag_en    (flag_en),
  .alu_res    (alu_res),
  .result     (result),
  .neg_q      (neg_q),
  .zero_q     (zero_q)
);

// File: tb/alu_shift_core_bench.sv
`timescale 1ns/1ps
module alu_shift_core_bench;

  localparam int NW = 8;
  localparam int NS = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [5:0]     ctrl = '0;
  logic [1:0]     shift_ctrl = '0;
  logic [NW-1:0]  opnd_a = '0;
  logic [NW-1:0]  opnd_b = '0;
  logic           flag_en = 1'b0;
  logic [NW-1:0]  result;
  logic           neg_q;
  logic           zero_q;

  logic [31:0]    wa = '0;
  logic [31:0]    wb = '0;
  logic [31:0]    wres;
  logic           wneg;
  logic           wzero;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_shift_core #(.W(NW), .SHL_DIST(NS)) u_alu_shift_core (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .shift_ctrl(shift_ctrl),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .flag_en(flag_en),
    .result(result), .neg_q(neg_q), .zero_q(zero_q)
  );

  alu_shift_core u_alu_shift_core_wide (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .shift_ctrl(shift_ctrl),
    .opnd_a(wa), .opnd_b(wb), .flag_en(flag_en),
    .result(wres), .neg_q(wneg), .zero_q(wzero)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Arithmetic restatement of the 8-bit ALU (R1..R4 semantics).
  function automatic int model_alu(input int c, input int a, input int b);
    int av, bv, f;
    av = ((c / 8) % 2 == 1) ? a : 0;
    if ((c / 2) % 2 == 1) av = 255 - av;
    bv = ((c / 4) % 2 == 1) ? b : 0;
    f  = c / 16;
    case (f)
      0: return av & bv;
      1: return av | bv;
      2: return 255 - bv;
      default: return (av + bv + (c % 2)) % 256;
    endcase
  endfunction

  function automatic int model_shift(input int s, input int r);
    if (s >= 2) return (r * 4) % 256;
    if (s == 1) return r / 2 + ((r >= 128) ? 128 : 0);
    return r;
  endfunction

  task automatic wide_case(input logic [5:0] c, input logic [31:0] exp, input string nm);
    ctrl = c;
    shift_ctrl = 2'b00;
    #1;
    chk(wres == exp, {"R5 ", nm}, wres, exp);
  endtask

  initial begin : watchdog
    #900000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lfsr;
    bit exp_n, exp_z;
    int r;
    lfsr = 16'hACE1;
    exp_n = 0;
    exp_z = 0;

    // Reset state, R11
    #7;
    chk(neg_q == 1'b0 && zero_q == 1'b0, "R11 reset flags", {neg_q, zero_q}, 0);
    chk(wneg == 1'b0 && wzero == 1'b0, "R11 reset flags wide", {wneg, wzero}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Named encodings on the 32-bit instance, R5
    wa = 32'h1234_5678;
    wb = 32'h0F0F_00F3;
    wide_case(6'b011000, wa, "A");
    wide_case(6'b010100, wb, "B");
    wide_case(6'b111100, wa + wb, "A+B");
    wide_case(6'b111101, wa + wb + 32'd1, "A+B+1");
    wide_case(6'b111001, wa + 32'd1, "A+1");
    wide_case(6'b110101, wb + 32'd1, "B+1");
    wide_case(6'b111111, wb - wa, "B-A");
    wide_case(6'b110110, wb - 32'd1, "B-1");
    wide_case(6'b111011, 32'd0 - wa, "-A");
    wide_case(6'b001100, wa & wb, "AND");
    wide_case(6'b011100, wa | wb, "OR");
    wide_case(6'b010000, 32'd0, "zero");
    wide_case(6'b110001, 32'd1, "one");
    wide_case(6'b110010, 32'hFFFF_FFFF, "minus one");
    ctrl = 6'b011000; shift_ctrl = 2'b10; #1;
    chk(wres == 32'h3456_7800, "R6 wide left by 8", wres, 32'h3456_7800);
    ctrl = 6'b110010; shift_ctrl = 2'b01; #1;
    chk(wres == 32'hFFFF_FFFF, "R7 wide sign fill", wres, 32'hFFFF_FFFF);

    // Sweep of the 8-bit instance: every control word, every A.
    for (int c = 0; c < 64; c++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 16; bi++) begin
          int b, s, e;
          string tg;
          b = (bi * 17 + 3) % 256;
          s = (a + bi + c) % 4;
          ctrl = 6'(c);
          opnd_a = 8'(a);
          opnd_b = 8'(b);
          shift_ctrl = 2'(s);
          #1;
          e = model_shift(s, model_alu(c, a, b));
          if ((c / 8) % 2 == 0 || (c / 4) % 2 == 0) tg = "R2 gate";
          else if ((c / 2) % 2 == 1) tg = "R3 invert";
          else if (c % 2 == 1) tg = "R4 carry";
          else tg = "R1 function";
          if (s == 3) tg = {tg, " R8 both"};
          else if (s == 2) tg = {tg, " R6 left"};
          else if (s == 1) tg = {tg, " R7 right"};
          else tg = {tg, " R8 pass"};
          chk(int'(result) == e, tg, result, e);
        end
      end
    end

    // Flag capture with pseudo-random stimulus, R9 R10 R11
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      chk(neg_q == exp_n, "R9 neg flag", neg_q, exp_n);
      chk(zero_q == exp_z, "R10 zero flag", zero_q, exp_z);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ctrl = lfsr[5:0];
      opnd_a = lfsr[13:6];
      opnd_b = {lfsr[2:0], lfsr[15:11]};
      shift_ctrl = lfsr[9:8];
      flag_en = lfsr[4] ^ lfsr[11];
      r = model_alu(int'(lfsr[5:0]), int'(opnd_a), int'(opnd_b));
      if (flag_en) begin
        exp_n = (r >= 128);
        exp_z = (r == 0);
      end
    end

    // Shifter-made zero must not set Z; shifter-made sign must not set N. R10 R9
    @(negedge clk);
    ctrl = 6'b011000; opnd_a = 8'h40; shift_ctrl = 2'b10; flag_en = 1'b1;
    #1;
    chk(result == 8'h00, "R6 left drops bits", result, 0);
    @(negedge clk);
    chk(zero_q == 1'b0, "R10 pre-shift zero", zero_q, 0);
    chk(neg_q == 1'b0, "R9 pre-shift sign", neg_q, 0);
    opnd_a = 8'h20;
    @(negedge clk);
    chk(neg_q == 1'b0, "R9 shifted into sign", neg_q, 0);
    ctrl = 6'b010000; flag_en = 1'b0;
    @(negedge clk);
    chk(zero_q == 1'b0, "R11 hold while disabled", zero_q, 0);
    flag_en = 1'b1;
    @(negedge clk);
    chk(zero_q == 1'b1, "R10 zero captured", zero_q, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule